// File: doc/BRIEF.md
# Truncated Unsigned Multiplier with Data-Driven Error Compensation

This block multiplies two unsigned N-bit operands and returns an N-bit result that approximates the upper half of the exact 2N-bit product. It saves area by forming only the partial-product bits whose column index is at least N-K. Here column c holds every AND term a[i]&b[j] with i+j = c. The lower N-K columns are never summed.

The error from the dropped columns is compensated by the operands themselves. Each AND term of column N-K-1, the highest dropped column, is injected into column N-K as a carry-in. All columns below N-K-1 are discarded outright. The correction is therefore zero when those terms are all zero, and largest when they are all one.

A single rounding bias bit of weight 2^(N-1), half a unit of the result, is also added. The block is purely combinational and has no clock or state. The result follows the operands within the same cycle. It is meant for datapaths that keep a constant word width, such as filters and transforms.

Top module: `dcorr_trunc_mul`

## Requirements
- R1: When either operand is zero the result is zero, including while the surrounding system is held in reset with zero operands.
- R2: The result equals floor(T / 2^N), where T is the sum of three parts: every term a[i]&b[j] with i+j >= N-K at weight 2^(i+j), the correction of R3, and the bias of R5. T never reaches 2^(2N) for the legal parameter range at N=8.
- R3: Each term a[i]&b[j] with i+j = N-K-1 adds 2^(N-K) to T. With N=8 and K=2, operands a=0x7F and b=0x01 give result 1, while a=0x5F and b=0x01 give result 0.
- R4: Terms with i+j < N-K-1 have no effect on the result. With N=8 and K=2, a=0x0F and b=0x01 give result 0.
- R5: A bias of 2^(N-1) is always added to T. With N=8, a=0x80 and b=0x01 give result 1.
- R6: For every operand pair the result R satisfies -2^N < R*2^N - a*b < 2^(N+1). The result is never more than one unit below, nor two units above, the truncated exact product.
- R7: With one operand equal to 1, the result is 0 or 1.
- R8: Over all operand pairs at N=8 and K=2, the magnitude of the mean error (R - a*b/2^N) is below 0.25 of a result unit. The bench reports the mean, the maximum magnitude and the variance of this error.
- R9: The result depends only on the current operands. It settles within the cycle in which they are applied, with no pipeline delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | N | Upper N bits of the corrected, biased, truncated product |

## Verification
The bound checks assume known, two-state operands that are held steady while the combinational tree settles. They also assume parameters with 1 <= K <= N-1, so that a highest dropped column exists and the bias falls inside the kept region. The bench applies a new operand pair shortly after each rising edge and samples on the falling edge, so every assertion sees settled values. It sweeps all 2^(2N) operand pairs at the default width, after directed pairs chosen so that a single correction term or the bias alone decides the result.

// File: rtl/dcorr_trunc_mul_pkg.sv
package dcorr_trunc_mul_pkg;

    // Accumulator width: one guard bit above the full product width.
    function automatic int acc_width(input int n);
        return 2 * n + 1;
    endfunction

    // Row count: N partial-product rows, one bias row, N-K correction rows.
    function automatic int row_count(input int n, input int k);
        return n + 1 + (n - k);
    endfunction

endpackage

// File: rtl/dcorr_pp_matrix.sv
module dcorr_pp_matrix
    import dcorr_trunc_mul_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 2,
    localparam int W    = acc_width(N),
    localparam int ROWS = row_count(N, K),
    localparam int LO   = N - K
) (
    input  logic [N-1:0]           a_i,
    input  logic [N-1:0]           b_i,
    output logic [ROWS-1:0][W-1:0] rows_o
);

    // Kept partial-product rows: row j carries a[c-j]&b[j] at column c >= LO.
    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar c = 0; c < W; c++) begin : g_col
            if ((c >= LO) && (c - j >= 0) && (c - j < N)) begin : g_kept
                assign rows_o[j][c] = a_i[c-j] & b_i[j];
            end else begin : g_void
                assign rows_o[j][c] = 1'b0;
            end
        end
    end

    // Rounding bias at half a result unit.
    assign rows_o[N] = W'(1) << (N - 1);

    // Highest dropped column: each of its terms lands one column up.
    for (genvar t = 0; t < LO; t++) begin : g_corr
        assign rows_o[N+1+t] = W'(a_i[LO-1-t] & b_i[t]) << LO;
    end

endmodule

// File: rtl/dcorr_csa_chain.sv
module dcorr_csa_chain #(
    parameter int W    = 17,
    parameter int ROWS = 15
) (
    input  logic [ROWS-1:0][W-1:0] rows_i,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           cry_o
);

    logic [ROWS-1:0][W-1:0] s_v;
    logic [ROWS-1:0][W-1:0] c_v;

    assign s_v[0] = rows_i[0];
    assign c_v[0] = '0;

    // One carry-save row per stage; the carry vector moves up one column.
    for (genvar r = 1; r < ROWS; r++) begin : g_stage
        logic [W-2:0] maj;
        assign maj = (s_v[r-1][W-2:0] & c_v[r-1][W-2:0])
                   | (s_v[r-1][W-2:0] & rows_i[r][W-2:0])
                   | (c_v[r-1][W-2:0] & rows_i[r][W-2:0]);
        assign s_v[r] = s_v[r-1] ^ c_v[r-1] ^ rows_i[r];
        assign c_v[r] = {maj, 1'b0};
    end

    assign sum_o = s_v[ROWS-1];
    assign cry_o = c_v[ROWS-1];

endmodule

// File: rtl/dcorr_ripple_add.sv
module dcorr_ripple_add #(
    parameter int W = 17
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);

    logic [W-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
        if (i < W - 1) begin : g_carry
            assign cy[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & cy[i]) | (y_i[i] & cy[i]);
        end
    end

endmodule

// File: rtl/dcorr_trunc_mul.sv
module dcorr_trunc_mul
    import dcorr_trunc_mul_pkg::*;
#(
    parameter int N = 8,
    parameter int K = 2
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] prod
);

    localparam int W    = acc_width(N);
    localparam int ROWS = row_count(N, K);

    logic [ROWS-1:0][W-1:0] pp_rows;
    logic [W-1:0]           cs_sum;
    logic [W-1:0]           cs_cry;
    logic [W-1:0]           acc_sum;
    logic                   unused_low;

    dcorr_pp_matrix #(.N(N), .K(K)) u_pp (
        .a_i    (op_a),
        .b_i    (op_b),
        .rows_o (pp_rows)
    );

    dcorr_csa_chain #(.W(W), .ROWS(ROWS)) u_csa (
        .rows_i (pp_rows),
        .sum_o  (cs_sum),
        .cry_o  (cs_cry)
    );

    dcorr_ripple_add #(.W(W)) u_add (
        .x_i (cs_sum),
        .y_i (cs_cry),
        .s_o (acc_sum)
    );

    assign prod       = acc_sum[2*N-1:N];
    assign unused_low = ^{acc_sum[N-1:0], acc_sum[2*N]};

endmodule

// File: rtl/dcorr_trunc_mul_chk.sv
module dcorr_trunc_mul_chk #(
    parameter int N = 8,
    parameter int K = 2
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N-1:0] prod_i,
    input logic         acc_top_i
);

    logic [2*N-1:0] exact;
    logic [N+1:0]   hi_trunc;
    logic [N+1:0]   res_ext;

    always_comb begin
        exact    = (2*N)'(a_i) * (2*N)'(b_i);
        hi_trunc = (N+2)'(exact >> N);
        res_ext  = (N+2)'(prod_i);

        // R1
        zero_in_zero_out_chk: assert (!((a_i == '0) || (b_i == '0)) || (prod_i == '0));
        // R6
        upper_bound_chk: assert (res_ext <= hi_trunc + (N+2)'(2));
        // R6
        lower_bound_chk: assert (res_ext + (N+2)'(1) >= hi_trunc);
        // R7
        unity_operand_chk: assert (!((a_i == N'(1)) || (b_i == N'(1))) || (prod_i <= N'(1)));
        // R2
        no_acc_overflow_chk: assert (!acc_top_i);
    end

endmodule

bind dcorr_trunc_mul dcorr_trunc_mul_chk #(.N(N), .K(K)) u_chk (
    .a_i       (op_a),
    .b_i       (op_b),
    .prod_i    (prod),
    .acc_top_i (acc_sum[2*N])
);

// File: tb/dcorr_trunc_mul_bench.sv
module dcorr_trunc_mul_bench;

    localparam int  N        = 8;
    localparam int  K        = 2;
    localparam int  LO       = N - K;
    localparam real MEAN_LIM = 0.25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic [N-1:0] prod;

    int  n_run  = 0;
    int  n_fail = 0;
    int  cycles = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    dcorr_trunc_mul #(.N(N), .K(K)) u_dcorr_trunc_mul (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    // Behavioural model from R2, R3, R5.
    function automatic int model(input int a, input int b);
        longint acc = 0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (((a >> i) & 1) == 1 && ((b >> j) & 1) == 1) begin
                    if (i + j >= LO)          acc += longint'(1) << (i + j);
                    else if (i + j == LO - 1) acc += longint'(1) << LO;
                end
            end
        end
        acc += longint'(1) << (N - 1);
        return int'(acc >> N);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: a=%0h b=%0h actual=%0d expected=%0d", req, op_a, op_b, got, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(posedge clk);
        #1;
        op_a = N'(a);
        op_b = N'(b);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<200000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        real sum_e, sum_e2, max_e, e, mean, var_e;
        int  diff;
        sum_e = 0.0; sum_e2 = 0.0; max_e = 0.0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", int'(prod), 0);
        rst_n = 1'b1;

        apply(0, 8'hFF);        check("R1 zero a", int'(prod), 0);
        apply(8'hA5, 0);        check("R1 zero b", int'(prod), 0);
        apply(8'h7F, 8'h01);    check("R3 corr on", int'(prod), 1);
        apply(8'h5F, 8'h01);    check("R3 corr off", int'(prod), 0);
        apply(8'h0F, 8'h01);    check("R4 low cols", int'(prod), 0);
        apply(8'h80, 8'h01);    check("R5 bias", int'(prod), 1);
        apply(8'hFF, 8'hFF);    check("R2 all ones", int'(prod), 254);
        apply(8'h01, 8'hC3);    check("R7 unity", int'(prod), model(1, 8'hC3));
        // R9: new operands are visible in the same cycle.
        apply(8'h40, 8'h40);    check("R9 same cycle", int'(prod), 16);

        for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
                apply(a, b);
                check("R2 exhaustive", int'(prod), model(a, b));
                diff = int'(prod) * (1 << N) - a * b;
                n_run++;
                if (diff <= -(1 << N) || diff >= (2 << N)) begin
                    n_fail++;
                    $display("FAIL R6: a=%0h b=%0h actual=%0d expected_range=(%0d,%0d)",
                             a, b, diff, -(1 << N), 2 << N);
                end
                e = real'(diff) / real'(1 << N);
                sum_e  += e;
                sum_e2 += e * e;
                if ((e < 0.0 ? -e : e) > max_e) max_e = (e < 0.0 ? -e : e);
            end
        end

        mean  = sum_e / real'(1 << (2 * N));
        var_e = sum_e2 / real'(1 << (2 * N)) - mean * mean;
        $display("error stats: mean=%f max=%f variance=%f", mean, max_e, var_e);
        n_run++;
        if ((mean < 0.0 ? -mean : mean) >= MEAN_LIM) begin
            n_fail++;
            $display("FAIL R8: actual=%f expected<%f", mean, MEAN_LIM);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule